// File: doc/BRIEF.md
# Palette-Mapped Pixel Shifter Serial Transmitter

This block is a write-only serial master transmitter built the way a display pixel shifter is built. It does not use a bit counter that toggles a clock pin. Each accepted byte is expanded into a 32-bit word of sixteen 2-bit pixels. In every pixel, bit 1 carries the serial clock level and bit 0 carries the data level. The word is then shifted out one pixel per pixel tick, and each pixel passes through a four-entry palette that turns the 2-bit code into the pin pattern. Because one serial bit spans two pixels, the bit rate is half the pixel rate: a 40 MHz pixel tick gives 20 Mbit/s.

The host hands over one byte per valid/ready transfer and is then free until the next byte is wanted. A one-entry holding register takes a second byte while the current byte is still going out. When that byte is queued, its first pixel follows the last pixel of the current byte directly, so the serial clock runs without idle periods. A pixel-enable strobe sets the pixel rate as a fraction of the system clock. The palette can be rewritten while the transmitter is idle. Writes made while it is busy are dropped.

Top module: `pxs_tx_top`

## Requirements
- R1: Data leaves most significant bit first: byte bit 7-k is presented during pixels 2k and 2k+1 of that byte (k = 0..7).
- R2: Each pixel code is {clock, data}. The clock bit is 0 in the first pixel of a bit pair and 1 in the second, and the data bit is the same in both pixels.
- R3: A pixel changes only on a cycle where pix_en is high, so each pixel is held for exactly one pix_en period. A byte keeps busy high for 16 pix_en periods.
- R4: The default palette after reset maps code 00 to pins 00, code 01 to pins 10, code 10 to pins 01 and code 11 to pins 11. Here pins_out[0] is the serial clock and pins_out[1] is the serial data.
- R5: A write with pal_we high stores pal_data into palette entry pal_idx only when no byte is active or queued. A write made while busy has no effect.
- R6: in_ready is high exactly when the holding register is empty, and a byte is taken on a cycle with in_valid and in_ready both high.
- R7: A byte queued while another is being sent starts on the pix_en tick that ends the current byte's last pixel, with busy held high throughout.
- R8: busy is high from the first pixel of a byte until the last pixel of the last queued byte has ended.
- R9: While idle the pins show palette entry 00. After reset in_ready is 1, busy is 0 and pins_out is 00.
- R10: Each byte produces exactly eight rising edges of the serial clock under the default palette.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel tick strobe; one pixel advances per high cycle |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Holding register empty; byte accepted this cycle when in_valid is high |
| pal_we | input | 1 | Palette entry write strobe |
| pal_idx | input | 2 | Palette entry selected by the 2-bit pixel code |
| pal_data | input | PIN_W | Pin pattern to store |
| busy | output | 1 | A byte is being shifted out |
| pins_out | output | PIN_W | Palette-mapped pin levels; bit 0 serial clock, bit 1 serial data by default |

## Verification
The assertions assume that pix_en is a plain strobe of any duty. They also assume that in_valid and in_data are held until in_ready is seen, and that palette writes arrive only when software expects the block to be idle. The checks for ignored writes therefore rely on the lock, not on the host's discipline. The stimulus drives every input on the falling clock edge from one divider process and task calls. It holds a byte until it has sampled in_ready high, and it issues one deliberate palette write while busy to exercise the lock. The pixel divider is changed only between streams, so the duration checks see a constant tick period.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int BYTE_W       = 8;
  localparam int PIX_W        = 2;
  localparam int PIX_PER_BIT  = 2;
  localparam int PIX_PER_BYTE = BYTE_W * PIX_PER_BIT;
  localparam int WORD_W       = PIX_PER_BYTE * PIX_W;
  localparam int CNT_W        = $clog2(PIX_PER_BYTE);
  localparam int PAL_N        = 1 << PIX_W;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pxs_expand.sv
module pxs_expand
  import pxs_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output word_t             word_out
);
  // Bit pair k (lowest-order first) carries byte bit BYTE_W-1-k.
  // Pixel 2k = {clk 0, d}, pixel 2k+1 = {clk 1, d}.
  for (genvar k = 0; k < BYTE_W; k++) begin : g_pair
    localparam int BASE = k * PIX_PER_BIT * PIX_W;
    assign word_out[BASE +: 4] = {1'b1, byte_in[BYTE_W-1-k], 1'b0, byte_in[BYTE_W-1-k]};
  end
endmodule

// File: rtl/pxs_palette.sv
module pxs_palette
  import pxs_pkg::*;
#(
  parameter int PIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             we,
  input  pix_t             idx,
  input  logic [PIN_W-1:0] wdata,
  input  pix_t             pix,
  output logic [PIN_W-1:0] pins
);
  logic [PAL_N-1:0][PIN_W-1:0] ent_q, ent_d, ent_rst;
  logic                        ent_en;

  // Reset pattern: pin 0 follows code bit 1 (clock), pin 1 follows code bit 0 (data).
  for (genvar e = 0; e < PAL_N; e++) begin : g_rst
    localparam logic [PIX_W-1:0] CODE = PIX_W'(e);
    always_comb begin
      ent_rst[e]    = '0;
      ent_rst[e][0] = CODE[1];
      ent_rst[e][1] = CODE[0];
    end
  end

  assign ent_en = we && !lock;

  always_comb begin
    ent_d      = ent_q;
    ent_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= ent_rst;
    else if (ent_en) ent_q <= ent_d;
  end

  assign pins = ent_q[pix];

  // R5: the palette is frozen while a byte is active or queued
  p_pal_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(ent_q));
endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic [BYTE_W-1:0] hold_byte,
  input  word_t             hold_word,
  output logic              busy,
  output logic              lock,
  output pix_t              pixel
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PIX_PER_BYTE - 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  pcnt_q, pcnt_d;
  word_t             shreg_q, shreg_d;
  logic              hold_v_q, hold_v_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              take, last, load, hold_en, sh_en;

  assign take    = in_valid && !hold_v_q;
  assign last    = active_q && (pcnt_q == LAST);
  assign load    = pix_en && hold_v_q && (!active_q || last);
  assign hold_en = take || load;
  assign sh_en   = pix_en && (active_q || hold_v_q);

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    active_d = active_q;
    pcnt_d   = pcnt_q;
    shreg_d  = shreg_q;
    if (take) begin
      hold_v_d = 1'b1;
      hold_d   = in_data;
    end
    if (active_q) begin
      if (last) begin
        active_d = 1'b0;
      end else begin
        shreg_d = shreg_q >> PIX_W;
        pcnt_d  = pcnt_q + 1'b1;
      end
    end
    if (load) begin
      shreg_d  = hold_word;
      pcnt_d   = '0;
      active_d = 1'b1;
      hold_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (hold_en) begin
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
      shreg_q  <= '0;
    end else if (sh_en) begin
      active_q <= active_d;
      pcnt_q   <= pcnt_d;
      shreg_q  <= shreg_d;
    end
  end

  assign in_ready  = !hold_v_q;
  assign hold_byte = hold_q;
  assign busy      = active_q;
  assign lock      = active_q || hold_v_q;
  assign pixel     = active_q ? shreg_q[PIX_W-1:0] : '0;

  // R3: without a pixel tick the shifter does not move
  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !pix_en) |=> ($stable(shreg_q) && $stable(pcnt_q)));
  // R6: a queued byte is neither lost nor overwritten before a tick
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !pix_en) |=> (hold_v_q && $stable(hold_q)));
  // R7: a queued byte follows the last pixel with no idle pixel
  p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && pix_en && hold_v_q) |=> (active_q && pcnt_q == '0));
  // R8: with nothing queued the last pixel ends the busy period
  p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && pix_en && !hold_v_q) |=> !active_q);
  // R10: inside a byte every tick advances one pixel
  p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pix_en && !last) |=> (active_q && pcnt_q == CNT_W'($past(pcnt_q) + 1'b1)));
endmodule

// File: rtl/pxs_tx_top.sv
module pxs_tx_top
  import pxs_pkg::*;
#(
  parameter int PIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pal_we,
  input  logic [PIX_W-1:0]  pal_idx,
  input  logic [PIN_W-1:0]  pal_data,
  output logic              busy,
  output logic [PIN_W-1:0]  pins_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [BYTE_W-1:0] hold_byte;
  word_t             hold_word;
  pix_t              pixel;
  logic              lock;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pxs_expand u_expand (
    .byte_in  (hold_byte),
    .word_out (hold_word)
  );

  pxs_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pix_en    (pix_en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .hold_byte (hold_byte),
    .hold_word (hold_word),
    .busy      (busy),
    .lock      (lock),
    .pixel     (pixel)
  );

  pxs_palette #(.PIN_W(PIN_W)) u_palette (
    .clk   (clk),
    .rst_n (rst_core_n),
    .lock  (lock),
    .we    (pal_we),
    .idx   (pal_idx),
    .wdata (pal_data),
    .pix   (pixel),
    .pins  (pins_out)
  );
endmodule

// File: tb/sim_pxs_tx_top.sv
module sim_pxs_tx_top;
  localparam int LOGN = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       pal_we = 1'b0;
  logic [1:0] pal_idx = '0;
  logic [1:0] pal_data = '0;
  logic       busy;
  logic [1:0] pins_out;

  pxs_tx_top u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .pal_we(pal_we),
    .pal_idx(pal_idx), .pal_data(pal_data), .busy(busy), .pins_out(pins_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int div = 1;
  int dcnt = 0;
  logic tick_q = 1'b0;
  logic logging = 1'b0;
  int nlog = 0;
  int busy_cyc = 0;
  logic [1:0] log_pins [LOGN];
  logic       log_busy [LOGN];
  logic [7:0] tx [256];
  logic [1:0] exp_pal [4];
  logic       summary_done = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Pixel tick divider, driven on the falling edge.
  always @(negedge clk) begin
    pix_en <= (dcnt == 0);
    dcnt   <= (dcnt + 1 >= div) ? 0 : dcnt + 1;
  end

  always @(posedge clk) tick_q <= pix_en;

  always @(negedge clk) begin
    if (logging) begin
      if (busy) busy_cyc++;
      if (tick_q && nlog < LOGN) begin
        log_pins[nlog] = pins_out;
        log_busy[nlog] = busy;
        nlog++;
      end
    end
  end

  task automatic start_log();
    nlog = 0;
    busy_cyc = 0;
    logging = 1'b1;
  endtask

  task automatic finish_log();
    while (busy || !in_ready) @(negedge clk);
    repeat (div * 4 + 4) @(negedge clk);
    logging = 1'b0;
  endtask

  task automatic send_stream(input int nb);
    start_log();
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1;
      in_data  = tx[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    finish_log();
  endtask

  task automatic pal_write(input logic [1:0] idx, input logic [1:0] val, input logic model);
    @(negedge clk);
    pal_we = 1'b1; pal_idx = idx; pal_data = val;
    @(negedge clk);
    pal_we = 1'b0;
    if (model) exp_pal[idx] = val;
  endtask

  task automatic check_stream(input int nb, input logic count_edges);
    int s = -1;
    int endi;
    int rises = 0;
    for (int i = 0; i < nlog; i++) if (s < 0 && log_busy[i]) s = i;
    chk(s >= 0, "R8 busy seen", s, 0);
    if (s < 0) return;
    for (int b = 0; b < nb; b++) begin
      logic ok = 1'b1;
      int bad_act = 0;
      int bad_exp = 0;
      for (int j = 0; j < 16; j++) begin
        logic [1:0] code;
        logic [1:0] ev;
        int ix = s + 16 * b + j;
        code = {1'(j % 2), tx[b][7 - j / 2]};
        ev = exp_pal[code];
        if (log_pins[ix] !== ev || log_busy[ix] !== 1'b1) begin
          if (ok) begin bad_act = int'(log_pins[ix]); bad_exp = int'(ev); end
          ok = 1'b0;
        end
      end
      chk(ok, $sformatf("R1 R2 R4 R7 byte %0d", b), bad_act, bad_exp);
    end
    endi = s + 16 * nb;
    chk(log_busy[endi] === 1'b0, "R8 busy ends after last pixel", int'(log_busy[endi]), 0);
    chk(log_pins[endi] === exp_pal[0], "R9 idle shows entry 00", int'(log_pins[endi]), int'(exp_pal[0]));
    chk(busy_cyc == 16 * nb * div, "R3 busy cycles", busy_cyc, 16 * nb * div);
    if (count_edges) begin
      for (int i = s; i <= endi; i++)
        if (log_pins[i][0] && !log_pins[i - 1][0]) rises++;
      chk(rises == 8 * nb, "R10 clock rising edges", rises, 8 * nb);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!summary_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    exp_pal[0] = 2'b00; exp_pal[1] = 2'b10; exp_pal[2] = 2'b01; exp_pal[3] = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(in_ready === 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    chk(busy === 1'b0, "R9 reset busy", int'(busy), 0);
    chk(pins_out === 2'b00, "R9 reset pins", int'(pins_out), 0);

    // Exhaustive byte sweep, back to back, full pixel rate (R1 R2 R4 R7 R10).
    div = 1;
    for (int i = 0; i < 256; i++) tx[i] = 8'(i);
    send_stream(256);
    check_stream(256, 1'b1);

    // Divided pixel rate (R3).
    div = 3;
    repeat (8) @(negedge clk);
    tx[0] = 8'hA5; tx[1] = 8'h00; tx[2] = 8'hFF; tx[3] = 8'h3C;
    send_stream(4);
    check_stream(4, 1'b1);

    div = 5;
    repeat (10) @(negedge clk);
    tx[0] = 8'h81;
    send_stream(1);
    check_stream(1, 1'b1);

    // R6: holding register handshake.
    div = 8;
    repeat (16) @(negedge clk);
    tx[0] = 8'h5A; tx[1] = 8'hC3;
    start_log();
    in_valid = 1'b1; in_data = tx[0];
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, "R6 ready low while byte held", int'(in_ready), 0);
    while (!busy) @(negedge clk);
    chk(in_ready === 1'b1, "R6 ready after load", int'(in_ready), 1);
    in_valid = 1'b1; in_data = tx[1];
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, "R6 ready low after accept", int'(in_ready), 0);
    finish_log();
    check_stream(2, 1'b1);

    // R5: rewrite the palette while idle.
    div = 2;
    repeat (8) @(negedge clk);
    pal_write(2'd0, 2'b11, 1'b1);
    pal_write(2'd1, 2'b00, 1'b1);
    pal_write(2'd2, 2'b10, 1'b1);
    pal_write(2'd3, 2'b01, 1'b1);
    @(negedge clk);
    chk(pins_out === 2'b11, "R5 R9 idle after palette write", int'(pins_out), 3);
    tx[0] = 8'h96; tx[1] = 8'h4B;
    send_stream(2);
    check_stream(2, 1'b0);

    // R5: a write while busy is dropped.
    tx[0] = 8'h71;
    start_log();
    in_valid = 1'b1; in_data = tx[0];
    @(negedge clk);
    in_valid = 1'b0;
    while (!busy) @(negedge clk);
    pal_write(2'd0, 2'b00, 1'b0);
    pal_write(2'd3, 2'b10, 1'b0);
    finish_log();
    check_stream(1, 1'b0);
    chk(pins_out === 2'b11, "R5 busy write ignored", int'(pins_out), 3);

    // Restore default palette and send once more.
    pal_write(2'd0, 2'b00, 1'b1);
    pal_write(2'd1, 2'b10, 1'b1);
    pal_write(2'd2, 2'b01, 1'b1);
    pal_write(2'd3, 2'b11, 1'b1);
    tx[0] = 8'h0F;
    send_stream(1);
    check_stream(1, 1'b1);

    summary_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule